// File: doc/BRIEF.md
# Programmable chip-select and wait-state generator

This block sits between a bus master and external memory. It decodes the upper part of a 24-bit bus address against four programmable areas and drives one active-low chip select for the area that is hit. For the area in use it reports whether the external data bus is 8 or 16 bits wide. It also stalls the bus cycle by the programmed number of wait states. An address that falls in no enabled area uses a separately programmed default area. The default area has no chip select of its own, but it has its own width and wait setting.

Software programs the block through a byte-wide write port. Each area has three registers: a base register, a mask register and a control register. The base register holds address bits 23..16, the upper byte of the address. A 1 in the mask register removes the matching base bit from the compare, and this sets the size of the area. The control register holds an enable bit, a width bit and a 3-bit wait code. The default area has only a control register. The bus master holds an access request and a stable address until it sees ready high. A separate input marks accesses to on-chip memory. Such accesses are not decoded and are not stalled.

Top module: `cs_wait_gen`

## Requirements
- R1: A write with `cfg_we_i` high stores `cfg_wdata_i` on the rising clock edge and takes effect from the next cycle. The register is chosen by `cfg_addr_i[3:2]`: 0 selects the base register, 1 the mask register and 2 the control register of the area in `cfg_addr_i[1:0]`. A value of 3 selects the default-area control register, and the low address bits are then ignored.
- R2: An area matches when the address bits [23:16] equal its base register in every bit position whose mask bit is 0. Positions whose mask bit is 1 are not compared.
- R3: Bit 7 of a control register enables its area. An area whose enable bit is 0 never asserts its chip select.
- R4: When several enabled areas match, only the lowest-numbered one asserts its chip select. At no time is more than one bit of `cs_n_o` low.
- R5: When no enabled area matches, all chip selects stay high and the width and wait code come from the default control register.
- R6: `bus_16b_o` equals bit 4 of the control register of the selected area (1 means 16-bit), or of the default area when no area is selected.
- R7: The wait code is held in control register bits [2:0]. Codes 0 to 3 hold `ready_o` low for exactly that many cycles after the request is raised.
- R8: Codes 4 to 7 hold `ready_o` low while `ext_wait_i` is high, and always for at least one cycle.
- R9: While `internal_i` is high, every chip select stays high and `ready_o` is high in the first cycle of the access.
- R10: After reset all areas are disabled. The default area is then 16-bit with wait code 3, and the base and mask registers are 0.
- R11: With base 0x01, mask 0x00 and the area enabled, area 0 is selected for exactly the addresses 0x010000 to 0x01FFFF.
- R12: While `bus_req_i` is low, all chip selects are high and `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register select |
| cfg_wdata_i | input | 8 | Configuration write data |
| bus_req_i | input | 1 | Access in progress; held until ready |
| bus_addr_i | input | 24 | Access address |
| internal_i | input | 1 | Access targets on-chip memory; decode suppressed |
| ext_wait_i | input | 1 | External wait request for wait codes 4 to 7 |
| cs_n_o | output | 4 | Active-low chip selects, one per area |
| bus_16b_o | output | 1 | Selected data bus width, 1 = 16-bit |
| ready_o | output | 1 | Access may complete this cycle |

## Verification
The assertions check several properties on every cycle:
- No more than one chip select is low (R4).
- A disabled area never asserts its chip select (R3).
- With no request (R12) or with an internal access (R9), all chip selects stay high.
- A fixed-code access releases ready only after exactly the coded number of stalls (R7), counted by the checker's own counter.
- An external-code access stays stalled while the wait input is high (R8).

The bench alone can show the address decode itself. It sweeps the full upper byte of the address against overlapping and disabled areas and compares each result with an arithmetic model. The bench also checks the reset contents, the 64-Kbyte example window, the timing of a configuration write and the measured stall length for each wait code.

// File: rtl/cs_wait_pkg.sv
package cs_wait_pkg;
  localparam int N_AREA  = 4;
  localparam int IDX_W   = 2;
  localparam int CFG_AW  = 2 + IDX_W;
  localparam int DATA_W  = 8;
  localparam int WAIT_W  = 3;

  typedef struct packed {
    logic              en;
    logic              wide;
    logic [WAIT_W-1:0] wcode;
  } area_ctl_t;

  // register group select in cfg address bits [3:2]
  localparam logic [1:0] GRP_BASE = 2'd0;
  localparam logic [1:0] GRP_MASK = 2'd1;
  localparam logic [1:0] GRP_CTL  = 2'd2;
  localparam logic [1:0] GRP_DFLT = 2'd3;

  localparam area_ctl_t DFLT_RESET = '{en: 1'b0, wide: 1'b1, wcode: 3'd3};
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import cs_wait_pkg::*;
#(
  parameter int BASE_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [CFG_AW-1:0]                waddr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [N_AREA-1:0][BASE_W-1:0]    base_o,
  output logic [N_AREA-1:0][BASE_W-1:0]    mask_o,
  output area_ctl_t [N_AREA-1:0]           ctl_o,
  output area_ctl_t                        dflt_o
);
  logic [1:0]       grp;
  logic [IDX_W-1:0] idx;
  area_ctl_t        wctl;
  logic             unused_wdata;

  assign grp  = waddr_i[CFG_AW-1 -: 2];
  assign idx  = waddr_i[IDX_W-1:0];
  assign wctl = '{en: wdata_i[7], wide: wdata_i[4], wcode: wdata_i[2:0]};
  assign unused_wdata = ^{wdata_i[6:5], wdata_i[3]};

  for (genvar i = 0; i < N_AREA; i++) begin : g_area
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[i] <= '0;
        mask_o[i] <= '0;
        ctl_o[i]  <= '0;
      end else if (we_i && idx == IDX_W'(i)) begin
        if (grp == GRP_BASE) base_o[i] <= wdata_i[BASE_W-1:0];
        if (grp == GRP_MASK) mask_o[i] <= wdata_i[BASE_W-1:0];
        if (grp == GRP_CTL)  ctl_o[i]  <= wctl;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        dflt_o <= DFLT_RESET;
    else if (we_i && grp == GRP_DFLT)   dflt_o <= '{en: 1'b0, wide: wctl.wide, wcode: wctl.wcode};
  end
endmodule

// File: rtl/cs_area_match.sv
module cs_area_match
  import cs_wait_pkg::*;
#(
  parameter int BASE_W = 8
) (
  input  logic [BASE_W-1:0]              addr_hi_i,
  input  logic [N_AREA-1:0][BASE_W-1:0]  base_i,
  input  logic [N_AREA-1:0][BASE_W-1:0]  mask_i,
  input  area_ctl_t [N_AREA-1:0]         ctl_i,
  output logic [N_AREA-1:0]              hit_o
);
  for (genvar i = 0; i < N_AREA; i++) begin : g_cmp
    assign hit_o[i] = ctl_i[i].en &&
                      (((addr_hi_i ^ base_i[i]) & ~mask_i[i]) == '0);
  end
endmodule

// File: rtl/cs_prio_select.sv
module cs_prio_select
  import cs_wait_pkg::*;
(
  input  logic [N_AREA-1:0]      hit_i,
  input  area_ctl_t [N_AREA-1:0] ctl_i,
  input  area_ctl_t              dflt_i,
  output logic [N_AREA-1:0]      sel_o,
  output area_ctl_t              sel_ctl_o
);
  // scan from the top down so the lowest index overwrites last
  always_comb begin
    sel_o     = '0;
    sel_ctl_o = dflt_i;
    for (int i = N_AREA - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        sel_o     = '0;
        sel_o[i]  = 1'b1;
        sel_ctl_o = ctl_i[i];
      end
    end
  end
endmodule

// File: rtl/cs_wait_ctrl.sv
module cs_wait_ctrl
  import cs_wait_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              bypass_i,
  input  logic [WAIT_W-1:0] wcode_i,
  input  logic              ext_wait_i,
  output logic              ready_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             fixed, done, stall;

  assign fixed = !wcode_i[WAIT_W-1];
  always_comb begin
    if (bypass_i)   done = 1'b1;
    else if (fixed) done = (cnt_q == CNT_W'(wcode_i));
    else            done = !ext_wait_i && (cnt_q != '0);
  end
  assign stall   = req_i && !done;
  assign ready_o = !stall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!stall)                 cnt_q <= '0;
    else if (cnt_q != CNT_MAX)       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cs_wait_gen.sv
module cs_wait_gen
  import cs_wait_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BASE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              bus_req_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              internal_i,
  input  logic              ext_wait_i,
  output logic [N_AREA-1:0] cs_n_o,
  output logic              bus_16b_o,
  output logic              ready_o
);
  logic [N_AREA-1:0][BASE_W-1:0] base, mask;
  area_ctl_t [N_AREA-1:0]        ctl;
  area_ctl_t                     dflt, sel_ctl;
  logic [N_AREA-1:0]             hit, sel, area_en;
  logic [WAIT_W-1:0]             sel_wcode;
  logic [BASE_W-1:0]             addr_hi;
  logic                          decode_on;
  logic                          unused_addr;

  assign addr_hi     = bus_addr_i[ADDR_W-1 -: BASE_W];
  assign unused_addr = ^bus_addr_i[ADDR_W-BASE_W-1:0] ^ sel_ctl.en;

  cs_cfg_regs #(.BASE_W(BASE_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .waddr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .base_o(base), .mask_o(mask), .ctl_o(ctl), .dflt_o(dflt)
  );

  cs_area_match #(.BASE_W(BASE_W)) u_match (
    .addr_hi_i(addr_hi), .base_i(base), .mask_i(mask), .ctl_i(ctl), .hit_o(hit)
  );

  cs_prio_select u_sel (
    .hit_i(hit), .ctl_i(ctl), .dflt_i(dflt), .sel_o(sel), .sel_ctl_o(sel_ctl)
  );

  cs_wait_ctrl #(.CNT_W(CNT_W)) u_wait (
    .clk_i, .rst_ni,
    .req_i(bus_req_i), .bypass_i(internal_i), .wcode_i(sel_wcode),
    .ext_wait_i(ext_wait_i), .ready_o(ready_o)
  );

  for (genvar i = 0; i < N_AREA; i++) begin : g_en
    assign area_en[i] = ctl[i].en;
  end

  assign sel_wcode = sel_ctl.wcode;
  assign decode_on = bus_req_i && !internal_i;
  assign cs_n_o    = ~(sel & {N_AREA{decode_on}});
  assign bus_16b_o = sel_ctl.wide;
endmodule

// File: rtl/cs_wait_gen_chk.sv
module cs_wait_gen_chk
  import cs_wait_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              internal_i,
  input logic              ext_wait_i,
  input logic [N_AREA-1:0] cs_n_i,
  input logic              ready_i,
  input logic [N_AREA-1:0] en_i,
  input logic [WAIT_W-1:0] wcode_i
);
  logic [3:0] stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          stall_q <= '0;
    else if (req_i && !ready_i)           stall_q <= (stall_q == 4'hF) ? stall_q : stall_q + 1'b1;
    else                                  stall_q <= '0;
  end

  assert_one_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_i));

  assert_disabled_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~cs_n_i) & ~en_i) == '0);

  assert_idle_no_cs_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (&cs_n_i) && ready_i);

  assert_internal_bypass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && internal_i) |-> (&cs_n_i) && ready_i);

  assert_fixed_wait_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_i && !internal_i && !wcode_i[WAIT_W-1]) |-> stall_q == 4'(wcode_i));

  assert_ext_wait_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !internal_i && wcode_i[WAIT_W-1] && ext_wait_i) |-> !ready_i);
endmodule

bind cs_wait_gen cs_wait_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(bus_req_i), .internal_i(internal_i),
  .ext_wait_i(ext_wait_i), .cs_n_i(cs_n_o), .ready_i(ready_o),
  .en_i(area_en), .wcode_i(sel_wcode)
);

// File: tb/cs_wait_gen_bench.sv
module cs_wait_gen_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        bus_req = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        internal = 1'b0;
  logic        ext_wait = 1'b0;
  logic [3:0]  cs_n;
  logic        bus_16b, ready;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  // bench copy of the programmed configuration
  logic [7:0] m_base [4];
  logic [7:0] m_mask [4];
  logic [7:0] m_ctl  [4];
  logic [7:0] m_dflt;

  always #10 clk = ~clk;

  cs_wait_gen u_cs_wait_gen (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .bus_req_i(bus_req), .bus_addr_i(bus_addr),
    .internal_i(internal), .ext_wait_i(ext_wait), .cs_n_o(cs_n),
    .bus_16b_o(bus_16b), .ready_o(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a[3:2] == 2'd0) m_base[a[1:0]] = d;
    if (a[3:2] == 2'd1) m_mask[a[1:0]] = d;
    if (a[3:2] == 2'd2) m_ctl[a[1:0]]  = d;
    if (a[3:2] == 2'd3) m_dflt         = d;
  endtask

  // area index 0..3, or 4 for default
  function automatic int exp_area(input logic [7:0] hi);
    for (int i = 0; i < 4; i++)
      if (m_ctl[i][7] && (((hi ^ m_base[i]) & ~m_mask[i]) == 8'h00)) return i;
    return 4;
  endfunction

  function automatic logic [3:0] exp_csn(input int a);
    return (a < 4) ? ~(4'b1 << a) : 4'hF;
  endfunction

  function automatic logic exp_wide(input int a);
    return (a < 4) ? m_ctl[a][4] : m_dflt[4];
  endfunction

  // run one access; returns number of cycles ready was low
  task automatic access(input logic [23:0] a, input int ext_k, output int n);
    @(negedge clk);
    bus_addr = a; bus_req = 1'b1; n = 0;
    while (1) begin
      ext_wait = (n < ext_k);
      #1;
      if (ready) break;
      n++;
      if (n > 40) break;
      @(negedge clk);
    end
    @(negedge clk);
    bus_req = 1'b0; ext_wait = 1'b0;
  endtask

  task automatic probe(input logic [23:0] a, input string req);
    int e;
    @(negedge clk);
    bus_addr = a; bus_req = 1'b1;
    #1;
    e = exp_area(a[23:16]);
    chk(cs_n == exp_csn(e), req, cs_n, exp_csn(e));
    chk(bus_16b == exp_wide(e), req, bus_16b, exp_wide(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_mask[i] = 0; m_ctl[i] = 0; end
    m_dflt = 8'h13;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10 reset state, R12 idle
    @(negedge clk); #1;
    chk(cs_n == 4'hF && ready, "R12", {cs_n, ready}, 5'h1F);
    probe(24'h000000, "R10");
    bus_req = 1'b0;
    access(24'h050000, 0, n);
    chk(n == 3, "R10 default wait", n, 3);

    // R1 write and effect timing; R11 64K window
    wr(4'hC, 8'h10);             // default: 16-bit, wait 0
    wr(4'h0, 8'h01);
    wr(4'h4, 8'h00);
    wr(4'h8, 8'h80);             // area0 enabled, 8-bit, wait 0
    probe(24'h010000, "R1");
    probe(24'h00FFFF, "R11");
    probe(24'h01FFFF, "R11");
    probe(24'h020000, "R11");
    probe(24'h01A5C3, "R11");
    @(negedge clk); bus_req = 1'b0;
    wr(4'hF, 8'h00);             // group 3 ignores low bits: default 8-bit
    probe(24'h700000, "R1 default alias");
    wr(4'hC, 8'h10);

    // R2 R3 R4 R5 R6 overlapping areas, full sweep of the upper byte
    wr(4'h0, 8'h40); wr(4'h4, 8'h0F); wr(4'h8, 8'h80);   // 0x40-0x4F 8-bit
    wr(4'h1, 8'h40); wr(4'h5, 8'h3F); wr(4'h9, 8'h90);   // 0x40-0x7F 16-bit
    wr(4'h2, 8'h81); wr(4'h6, 8'h7E); wr(4'hA, 8'h80);   // odd 0x81..0xFF
    wr(4'h3, 8'h00); wr(4'h7, 8'h00); wr(4'hB, 8'h10);   // disabled, matches 0x00
    wr(4'hC, 8'h00);
    for (int h = 0; h < 256; h++) probe({h[7:0], 16'h5A5A}, "R2 R4 R5 R6 sweep");
    probe(24'h000000, "R3 disabled");
    @(negedge clk); bus_req = 1'b0;

    // R12: no request, no chip select
    @(negedge clk); bus_addr = 24'h440000; #1;
    chk(cs_n == 4'hF, "R12", cs_n, 4'hF);

    // R7 fixed wait codes
    for (int c = 0; c < 4; c++) begin
      wr(4'h8, 8'h80 | c[7:0]);
      access(24'h420000, 0, n);
      chk(n == c, "R7", n, c);
    end
    wr(4'hC, 8'h02);
    access(24'h300000, 0, n);
    chk(n == 2, "R7 default", n, 2);

    // R8 external wait
    wr(4'h8, 8'h85);
    access(24'h420000, 0, n); chk(n == 1, "R8", n, 1);
    access(24'h420000, 1, n); chk(n == 1, "R8", n, 1);
    access(24'h420000, 4, n); chk(n == 4, "R8", n, 4);
    access(24'h420000, 9, n); chk(n == 9, "R8", n, 9);

    // R9 internal suppresses decode and waits
    wr(4'h8, 8'h83);
    @(negedge clk); internal = 1'b1;
    access(24'h420000, 0, n);
    chk(n == 0, "R9 wait", n, 0);
    @(negedge clk); bus_req = 1'b1; #1;
    chk(cs_n == 4'hF, "R9 cs", cs_n, 4'hF);
    @(negedge clk); bus_req = 1'b0; internal = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule